// File: doc/BRIEF.md
# Charge-Pump Speedup Timer Controller

This block shortens the settling time of a frequency synthesizer loop after a channel change. Each time new divider settings are written, it can raise the charge-pump current select to the high-current setting and close an open-drain loop-filter switch for a programmable interval. When the interval ends it drops back to the low steady-state current. The interval length is a 7-bit count of 64-cycle units of the reference clock, so it spans from 64 to 8128 reference cycles.

The timer count, the speedup enable and the switch-hold-off control arrive together with the divider write, which is marked by a one-cycle load strobe. A new load restarts the interval even if one is already running. A power-down input overrides everything: both outputs go low at once and the timer goes idle.

Top module: `spd_timer_ctrl`

## Requirements
- R1: After a starting load, cp_high_o is high for exactly tm_i × 64 clock cycles, beginning in the cycle after the edge at which load_i is sampled high.
- R2: A load with boost_en_i = 0 or with tm_i = 0 starts no interval, and stops any running one: cp_high_o is low from the next cycle on.
- R3: A load with boost_en_i = 1, tm_i ≠ 0 and pwr_down_i = 0 drives cp_high_o high in the next cycle.
- R4: When sw_off_i was 0 at the starting load, sw_on_o is high in exactly the same cycles as cp_high_o.
- R5: When sw_off_i was 1 at the starting load, sw_on_o stays low for the whole interval while cp_high_o is high.
- R6: While pwr_down_i is 1, cp_high_o and sw_on_o are 0 in the same cycle, and a running interval is cancelled: no speedup resumes when pwr_down_i returns to 0.
- R7: A starting load during a running interval restarts the count, so the new interval lasts its full tm_i × 64 cycles from that load.
- R8: A load while pwr_down_i is 1 is ignored: no interval follows, either during power-down or after it is released.
- R9: While rst_ni is low both outputs are 0, and after reset they stay 0 until a starting load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe: new divider settings latched |
| tm_i | input | 7 | Interval length in units of 64 clock cycles; 0 means no interval |
| boost_en_i | input | 1 | 1 enables the high-current interval on load |
| sw_off_i | input | 1 | 0: filter switch follows the interval; 1: switch held off |
| pwr_down_i | input | 1 | 1 forces low current, switch off and the timer idle |
| cp_high_o | output | 1 | 1 selects the high charge-pump current |
| sw_on_o | output | 1 | 1 turns the open-drain filter switch on |

## Verification
The properties take load_i to be a single-cycle strobe whose tm_i, boost_en_i and sw_off_i values are valid in that same cycle, and they take an interval to end naturally only when no load or power-down intervened in the cycle before the fall. The checker keeps its own elapsed-cycle count from each starting load and compares it to tm_i × 64 at the falling edge of cp_high_o. The stimulus drives each load as a one-cycle pulse placed between clock edges, changes pwr_down_i only between edges, and covers the smallest and largest counts, a zero count, a disabled load, a restart in mid-interval and loads during power-down.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int unsigned SPD_TM_W  = 7;
  localparam int unsigned SPD_PRE_W = 6;

  function automatic int unsigned spd_cycles(input int unsigned tm, input int unsigned pre_w);
    return tm << pre_w;
  endfunction
endpackage

// File: rtl/spd_cfg_decode.sv
// Qualifies the load strobe and keeps the switch hold-off setting of the last accepted load.
module spd_cfg_decode #(
  parameter int TM_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            pwr_down_i,
  input  logic [TM_W-1:0] tm_i,
  input  logic            boost_en_i,
  input  logic            sw_off_i,
  output logic            accept_o,
  output logic            start_o,
  output logic            sw_off_q_o
);
  logic sw_off_q;

  assign accept_o   = load_i & ~pwr_down_i;
  assign start_o    = accept_o & boost_en_i & (tm_i != '0);
  assign sw_off_q_o = sw_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sw_off_q <= 1'b1;
    else if (accept_o) sw_off_q <= sw_off_i;
  end
endmodule

// File: rtl/spd_prescale.sv
// Divides the reference clock into units of 2**PRE_W cycles while running.
module spd_prescale #(
  parameter int PRE_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  if (PRE_W == 0) begin : g_no_pre
    assign tick_o = run_i & ~clear_i;
  end else begin : g_pre
    logic [PRE_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (clear_i || !run_i) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
    end
    assign tick_o = run_i & ~clear_i & (&cnt_q);
  end
endmodule

// File: rtl/spd_unit_cnt.sv
// Counts down remaining units; last_o flags the final unit.
module spd_unit_cnt #(
  parameter int TM_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TM_W-1:0] value_i,
  input  logic            tick_i,
  output logic            last_o
);
  logic [TM_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rem_q <= '0;
    else if (load_i)                    rem_q <= value_i;
    else if (tick_i && rem_q != '0)     rem_q <= rem_q - 1'b1;
  end

  assign last_o = (rem_q == TM_W'(1));
endmodule

// File: rtl/spd_timer_ctrl.sv
module spd_timer_ctrl #(
  parameter int TM_W  = spd_pkg::SPD_TM_W,
  parameter int PRE_W = spd_pkg::SPD_PRE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TM_W-1:0] tm_i,
  input  logic            boost_en_i,
  input  logic            sw_off_i,
  input  logic            pwr_down_i,
  output logic            cp_high_o,
  output logic            sw_on_o
);
  logic accept, start, sw_off_q;
  logic tick, last_unit;
  logic active_q;

  spd_cfg_decode #(.TM_W(TM_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .pwr_down_i (pwr_down_i),
    .tm_i       (tm_i),
    .boost_en_i (boost_en_i),
    .sw_off_i   (sw_off_i),
    .accept_o   (accept),
    .start_o    (start),
    .sw_off_q_o (sw_off_q)
  );

  spd_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .run_i   (active_q & ~pwr_down_i),
    .tick_o  (tick)
  );

  spd_unit_cnt #(.TM_W(TM_W)) u_unit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .value_i (tm_i),
    .tick_i  (tick),
    .last_o  (last_unit)
  );

  // Interval flag: a load sets or clears it, the final unit ends it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                active_q <= 1'b0;
    else if (pwr_down_i)        active_q <= 1'b0;
    else if (accept)            active_q <= start;
    else if (tick && last_unit) active_q <= 1'b0;
  end

  assign cp_high_o = active_q & ~pwr_down_i;
  assign sw_on_o   = cp_high_o & ~sw_off_q;
endmodule

// File: rtl/spd_timer_ctrl_chk.sv
module spd_timer_ctrl_chk #(
  parameter int TM_W  = 7,
  parameter int PRE_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            load_i,
  input logic [TM_W-1:0] tm_i,
  input logic            boost_en_i,
  input logic            sw_off_i,
  input logic            pwr_down_i,
  input logic            cp_high_o,
  input logic            sw_on_o
);
  localparam int LEN_W = TM_W + PRE_W + 1;

  logic             go;
  logic [LEN_W-1:0] ck_len, ck_cnt;

  assign go = load_i & ~pwr_down_i & boost_en_i & (tm_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_len <= '0;
      ck_cnt <= '0;
    end else if (go) begin
      ck_len <= LEN_W'(tm_i) << PRE_W;
      ck_cnt <= '0;
    end else if (cp_high_o) begin
      ck_cnt <= ck_cnt + 1'b1;
    end
  end

  p_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cp_high_o) && !pwr_down_i && !$past(pwr_down_i) && !$past(load_i)) |-> (ck_cnt == ck_len));

  p_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_high_o && !pwr_down_i) |-> (ck_cnt < ck_len));

  p_no_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !pwr_down_i && (!boost_en_i || tm_i == '0)) |=> !cp_high_o);

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> (cp_high_o || pwr_down_i));

  p_sw_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !sw_off_i) |=> (sw_on_o == cp_high_o));

  p_sw_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !pwr_down_i && sw_off_i) |=> !sw_on_o);

  p_sw_needs_cp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_on_o |-> cp_high_o);

  p_pd_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> (!cp_high_o && !sw_on_o));

  p_pd_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && pwr_down_i) |=> !cp_high_o);

  p_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cp_high_o) |-> $past(go));
endmodule

bind spd_timer_ctrl spd_timer_ctrl_chk #(.TM_W(TM_W), .PRE_W(PRE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .tm_i       (tm_i),
  .boost_en_i (boost_en_i),
  .sw_off_i   (sw_off_i),
  .pwr_down_i (pwr_down_i),
  .cp_high_o  (cp_high_o),
  .sw_on_o    (sw_on_o)
);

// File: tb/spd_timer_ctrl_tb_top.sv
module spd_timer_ctrl_tb_top;
  typedef struct packed {
    logic [6:0]  tm;
    logic        en;
    logic        off;
    logic [13:0] len;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{7'd1,   1'b1, 1'b0, 14'd64},
    '{7'd3,   1'b1, 1'b1, 14'd192},
    '{7'd0,   1'b1, 1'b0, 14'd0},
    '{7'd5,   1'b0, 1'b0, 14'd0},
    '{7'd2,   1'b1, 1'b0, 14'd128},
    '{7'd127, 1'b1, 1'b0, 14'd8128},
    '{7'd4,   1'b1, 1'b1, 14'd256}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [6:0] tm = '0;
  logic       en = 1'b0;
  logic       off = 1'b0;
  logic       pd = 1'b0;
  logic       cp_high, sw_on;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  spd_timer_ctrl dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .load_i     (load),
    .tm_i       (tm),
    .boost_en_i (en),
    .sw_off_i   (off),
    .pwr_down_i (pd),
    .cp_high_o  (cp_high),
    .sw_on_o    (sw_on)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; pulses load over one posedge, returns at the following negedge.
  task automatic do_load(input logic [6:0] t, input logic e, input logic o);
    tm = t; en = e; off = o; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Counts high cycles of cp_high; returns count and number of cycles where sw_on mismatched.
  task automatic measure(input logic exp_sw, output int len, output int sw_bad);
    len = 0; sw_bad = 0;
    while (cp_high && len < 20000) begin
      if (sw_on !== exp_sw) sw_bad++;
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int len, bad;
    // R9 reset state
    repeat (3) @(negedge clk);
    check(cp_high == 0 && sw_on == 0, "R9 in reset", cp_high, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(cp_high == 0 && sw_on == 0, "R9 idle after reset", cp_high, 0);

    // Vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      do_load(VECS[i].tm, VECS[i].en, VECS[i].off);
      if (VECS[i].len != 0)
        check(cp_high == 1, "R3 start next cycle", cp_high, 1);
      measure(!VECS[i].off, len, bad);
      check(len == int'(VECS[i].len), (VECS[i].len == 0) ? "R2 no interval" : "R1 length", len, int'(VECS[i].len));
      check(bad == 0, VECS[i].off ? "R5 switch held off" : "R4 switch follows", bad, 0);
      repeat (3) @(negedge clk);
    end

    // R7 restart mid-interval
    do_load(7'd2, 1'b1, 1'b0);
    repeat (50) @(negedge clk);
    do_load(7'd1, 1'b1, 1'b0);
    measure(1'b1, len, bad);
    check(len == 64, "R7 restart length", len, 64);

    // R2 disabled load stops a running interval
    do_load(7'd3, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    do_load(7'd3, 1'b0, 1'b0);
    check(cp_high == 0, "R2 disabled load stops", cp_high, 0);

    // R6 power-down mid-interval
    repeat (3) @(negedge clk);
    do_load(7'd2, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    pd = 1'b1;
    #1;
    check(cp_high == 0 && sw_on == 0, "R6 immediate quiet", cp_high + sw_on, 0);
    repeat (5) @(negedge clk);
    pd = 1'b0;
    len = 0;
    repeat (200) begin @(negedge clk); if (cp_high) len++; end
    check(len == 0, "R6 no resume", len, 0);

    // R8 load during power-down ignored
    pd = 1'b1;
    @(negedge clk);
    do_load(7'd5, 1'b1, 1'b0);
    check(cp_high == 0, "R8 quiet during pd", cp_high, 0);
    pd = 1'b0;
    len = 0;
    repeat (400) begin @(negedge clk); if (cp_high) len++; end
    check(len == 0, "R8 nothing after release", len, 0);

    // R9 asynchronous reset mid-interval
    do_load(7'd3, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(cp_high == 0 && sw_on == 0, "R9 async reset", cp_high, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    check(cp_high == 0, "R9 stays idle", cp_high, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule